// File: doc/BRIEF.md
# Exception Status Register Unit

This unit holds the live control status word of a processor core, a saved copy of it, and a second saved copy kept for handlers that run on a shadow register set. When the pipeline signals that an exception or an external interrupt is being taken, the unit preserves the old word in the proper saved copy. It then switches the live word into handler mode. On a return from exception it restores the live word from a saved copy. Software reads and writes all three words through a small indexed port. The unit also drives an interrupt-accept gate that the interrupt logic uses to decide whether an external request may be taken.

Each cycle a decoder reduces the inputs to one named event. EV_IDLE means nothing happens. EV_IRQ is an accepted external interrupt, EV_BREAK is a break, and EV_EXC is any other exception. EV_RET is an exception return and EV_SWWR is a software write. Priority runs from the exception events first, then EV_RET, then EV_SWWR. A lower event raised in the same cycle is dropped. A routing stage decides whether an entry saves to the normal copy, to the shadow copy, or to neither. The register stage applies the event to the three words.

The word is 32 bits wide. Only bits 3:0 carry fields: bit 0 is the interrupt enable (IEN), bit 1 is user mode (USR), bit 2 is exception mode (EXM), and bit 3 is interrupt-handler mode (IHM). All other bits read as 0.

Top module: `exc_status_unit`

## Requirements
- R1: After reset the live word, the saved word and the shadow saved word all read 0, and irq_gate is 0.
- R2: Software index 0 selects the live word, index 1 the saved word, index 2 the shadow saved word, and index 3 always reads 0. A write stores only the implemented field bits (IEN bit 0, USR bit 1, EXM bit 2, IHM bit 3). Bits 31:4 always read 0. The value written reads back on sw_rdata and on the matching output.
- R3: When built without memory management (HAS_MMU=0), USR and EXM read 0 in every word and are never set. When built without shadow sets (HAS_SHADOW=0), the shadow saved word reads 0, writes to index 2 are dropped, and every save goes to the saved word.
- R4: Taking any exception sets EXM in the live word and clears USR and IEN, all in the same update.
- R5: An accepted external interrupt (exc_cause 0) sets IHM. A break (cause 1) or another exception (cause 2 or 3) leaves IHM unchanged.
- R6: An interrupt or non-break exception copies the pre-entry live word into a saved word only when EXM was 0 at entry. A break never changes either saved word.
- R7: An interrupt with shd_req=1 and a non-zero shd_set saves into the shadow saved word instead of the saved word. This holds only when shadow sets are present.
- R8: While IEN is 0, an external interrupt strobe changes nothing. Causes 1 to 3 are taken whatever IEN holds.
- R9: An exception-return strobe loads the live word from the saved word, or from the shadow saved word when eret_shd=1 and shadow sets are present.
- R10: In one cycle an accepted exception beats a return, and a return beats a software write. The losing operations have no effect.
- R11: EXM and USR are never 1 together in the live word.
- R12: irq_gate follows the IEN bit of the live word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception or interrupt entry strobe |
| exc_cause | input | 2 | 0 external interrupt, 1 break, 2 or 3 other exception |
| shd_req | input | 1 | Interrupt requests a shadow register set |
| shd_set | input | SET_W | Requested register set number (0 is the normal set) |
| eret | input | 1 | Exception-return strobe |
| eret_shd | input | 1 | Return restores from the shadow saved word |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | 2 | Software register index |
| sw_wdata | input | DATA_W | Software write data |
| sw_rdata | output | DATA_W | Software read data for sw_addr |
| status_o | output | DATA_W | Live status word |
| estatus_o | output | DATA_W | Saved status word |
| sstatus_o | output | DATA_W | Shadow saved status word |
| irq_gate | output | 1 | External interrupts may be accepted |

## Verification
The check that EXM and USR are never both set assumes software never writes a word that has both bits set. It also assumes software never places such a word in a saved copy that a return could restore. The bench therefore clears USR in any generated write data that has EXM set. The other properties rely on the strobes being clean, synchronous levels that can be compared against the live state of the previous cycle. The bench drives every input on the falling edge and randomises each strobe independently, so all event collisions occur. A second instance built without memory management or shadow sets receives the same stimulus.

// File: rtl/esu_pkg.sv
package esu_pkg;
    localparam int FLD_W   = 4;
    localparam int BIT_IEN = 0;
    localparam int BIT_USR = 1;
    localparam int BIT_EXM = 2;
    localparam int BIT_IHM = 3;

    localparam logic [1:0] IDX_LIVE   = 2'd0;
    localparam logic [1:0] IDX_SAVED  = 2'd1;
    localparam logic [1:0] IDX_SHADOW = 2'd2;

    typedef enum logic [1:0] {
        CAUSE_IRQ   = 2'd0,
        CAUSE_BREAK = 2'd1,
        CAUSE_OTHER = 2'd2,
        CAUSE_RSVD  = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_IRQ,
        EV_BREAK,
        EV_EXC,
        EV_RET,
        EV_SWWR
    } event_e;
endpackage

// File: rtl/esu_event_decode.sv
module esu_event_decode
    import esu_pkg::*;
(
    input  logic       exc_valid,
    input  logic [1:0] exc_cause,
    input  logic       ien,
    input  logic       eret,
    input  logic       sw_we,
    output event_e     ev
);
    always_comb begin
        ev = EV_IDLE;
        if (exc_valid && cause_e'(exc_cause) == CAUSE_IRQ && ien)
            ev = EV_IRQ;
        else if (exc_valid && cause_e'(exc_cause) == CAUSE_BREAK)
            ev = EV_BREAK;
        else if (exc_valid && cause_e'(exc_cause) != CAUSE_IRQ)
            ev = EV_EXC;
        else if (eret)
            ev = EV_RET;
        else if (sw_we)
            ev = EV_SWWR;
    end
endmodule

// File: rtl/esu_save_route.sv
module esu_save_route
    import esu_pkg::*;
#(
    parameter bit HAS_SHADOW = 1'b1,
    parameter int SET_W      = 3
) (
    input  event_e           ev,
    input  logic             exm,
    input  logic             shd_req,
    input  logic [SET_W-1:0] shd_set,
    output logic             save_main,
    output logic             save_shadow
);
    logic saving;
    logic use_shd;

    assign saving = (ev == EV_IRQ || ev == EV_EXC) && !exm;

    generate
        if (HAS_SHADOW) begin : g_shadow
            assign use_shd = (ev == EV_IRQ) && shd_req && (shd_set != '0);
        end else begin : g_plain
            assign use_shd = 1'b0;
        end
    endgenerate

    assign save_main   = saving && !use_shd;
    assign save_shadow = saving && use_shd;
endmodule

// File: rtl/esu_status_regs.sv
module esu_status_regs
    import esu_pkg::*;
#(
    parameter bit HAS_MMU    = 1'b1,
    parameter bit HAS_SHADOW = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  event_e           ev,
    input  logic             save_main,
    input  logic             save_shadow,
    input  logic             eret_shd,
    input  logic [1:0]       sw_addr,
    input  logic [FLD_W-1:0] sw_wdata,
    output logic [FLD_W-1:0] st_q,
    output logic [FLD_W-1:0] es_q,
    output logic [FLD_W-1:0] ss_q
);
    localparam logic [FLD_W-1:0] FMASK = {1'b1, HAS_MMU, HAS_MMU, 1'b1};
    localparam logic [FLD_W-1:0] SMASK = HAS_SHADOW ? FMASK : '0;
    localparam logic [FLD_W-1:0] ENTRY_CLR = FLD_W'((1 << BIT_IEN) | (1 << BIT_USR));
    localparam logic [FLD_W-1:0] ENTRY_SET = FLD_W'(1 << BIT_EXM);
    localparam logic [FLD_W-1:0] IHM_SET   = FLD_W'(1 << BIT_IHM);

    logic [FLD_W-1:0] st_d, es_d, ss_d, entry_w;

    assign entry_w = (st_q & ~ENTRY_CLR) | ENTRY_SET;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            es_q <= '0;
            ss_q <= '0;
        end else begin
            st_q <= st_d;
            es_q <= es_d;
            ss_q <= ss_d;
        end
    end

    always_comb begin
        st_d = st_q;
        es_d = save_main   ? st_q : es_q;
        ss_d = save_shadow ? (st_q & SMASK) : ss_q;
        unique case (ev)
            EV_IRQ:   st_d = (entry_w | IHM_SET) & FMASK;
            EV_BREAK,
            EV_EXC:   st_d = entry_w & FMASK;
            EV_RET:   st_d = ((eret_shd && HAS_SHADOW) ? ss_q : es_q) & FMASK;
            EV_SWWR: begin
                unique case (sw_addr)
                    IDX_LIVE:   st_d = sw_wdata & FMASK;
                    IDX_SAVED:  es_d = sw_wdata & FMASK;
                    IDX_SHADOW: ss_d = sw_wdata & SMASK;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    AST_EXM_USR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q[BIT_EXM] && st_q[BIT_USR])); // R11
    AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_IRQ || ev == EV_BREAK || ev == EV_EXC) |=>
        (st_q[BIT_EXM] == HAS_MMU) && !st_q[BIT_IEN] && !st_q[BIT_USR]); // R4
    AST_IHM_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_IRQ) |=> st_q[BIT_IHM]); // R5
    AST_NO_RESAVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev == EV_IRQ || ev == EV_EXC) && st_q[BIT_EXM]) |=>
        ($stable(es_q) && $stable(ss_q))); // R6
    AST_BREAK_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_BREAK) |=> ($stable(es_q) && $stable(ss_q))); // R6
endmodule

// File: rtl/exc_status_unit.sv
module exc_status_unit
    import esu_pkg::*;
#(
    parameter int  DATA_W     = 32,
    parameter bit  HAS_MMU    = 1'b1,
    parameter bit  HAS_SHADOW = 1'b1,
    parameter int  NUM_SETS   = 8,
    localparam int SET_W      = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [1:0]        exc_cause,
    input  logic              shd_req,
    input  logic [SET_W-1:0]  shd_set,
    input  logic              eret,
    input  logic              eret_shd,
    input  logic              sw_we,
    input  logic [1:0]        sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] estatus_o,
    output logic [DATA_W-1:0] sstatus_o,
    output logic              irq_gate
);
    event_e           ev;
    logic             save_main, save_shadow;
    logic [FLD_W-1:0] st_q, es_q, ss_q, rd_fld;

    esu_event_decode u_decode (
        .exc_valid (exc_valid),
        .exc_cause (exc_cause),
        .ien       (st_q[BIT_IEN]),
        .eret      (eret),
        .sw_we     (sw_we),
        .ev        (ev)
    );

    esu_save_route #(.HAS_SHADOW(HAS_SHADOW), .SET_W(SET_W)) u_route (
        .ev          (ev),
        .exm         (st_q[BIT_EXM]),
        .shd_req     (shd_req),
        .shd_set     (shd_set),
        .save_main   (save_main),
        .save_shadow (save_shadow)
    );

    esu_status_regs #(.HAS_MMU(HAS_MMU), .HAS_SHADOW(HAS_SHADOW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .save_main   (save_main),
        .save_shadow (save_shadow),
        .eret_shd    (eret_shd),
        .sw_addr     (sw_addr),
        .sw_wdata    (sw_wdata[FLD_W-1:0]),
        .st_q        (st_q),
        .es_q        (es_q),
        .ss_q        (ss_q)
    );

    always_comb begin
        unique case (sw_addr)
            IDX_LIVE:   rd_fld = st_q;
            IDX_SAVED:  rd_fld = es_q;
            IDX_SHADOW: rd_fld = ss_q;
            default:    rd_fld = '0;
        endcase
    end

    assign sw_rdata  = DATA_W'(rd_fld);
    assign status_o  = DATA_W'(st_q);
    assign estatus_o = DATA_W'(es_q);
    assign sstatus_o = DATA_W'(ss_q);
    assign irq_gate  = st_q[BIT_IEN];

    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == 2'd0 && !irq_gate && !eret && !sw_we) |=>
        ($stable(status_o) && $stable(estatus_o) && $stable(sstatus_o))); // R8
    AST_RET_WINS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid && eret && !eret_shd && sw_we) |=>
        (status_o == $past(estatus_o))); // R10
endmodule

// File: tb/exc_status_unit_tb.sv
module exc_status_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 0, shd_req = 0, eret = 0, eret_shd = 0, sw_we = 0;
    logic [1:0]  exc_cause = 0, sw_addr = 0;
    logic [2:0]  shd_set = 0;
    logic [31:0] sw_wdata = 0;
    logic [31:0] rd_a, st_a, es_a, ss_a, rd_b, st_b, es_b, ss_b;
    logic        g_a, g_b;
    int          n_chk = 0, n_bad = 0;
    string       cur_req = "R1";
    bit          done = 0;

    logic [3:0]  m_st [2];
    logic [3:0]  m_es [2];
    logic [3:0]  m_ss [2];

    always #5 clk = ~clk;

    exc_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .shd_req(shd_req), .shd_set(shd_set), .eret(eret), .eret_shd(eret_shd),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(rd_a),
        .status_o(st_a), .estatus_o(es_a), .sstatus_o(ss_a), .irq_gate(g_a));

    exc_status_unit #(.HAS_MMU(1'b0), .HAS_SHADOW(1'b0)) u_dut_min (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .shd_req(shd_req), .shd_set(shd_set), .eret(eret), .eret_shd(eret_shd),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(rd_b),
        .status_o(st_b), .estatus_o(es_b), .sstatus_o(ss_b), .irq_gate(g_b));

    // Behavioural reference: k=0 full build, k=1 build without MMU or shadow sets
    always @(posedge clk or negedge rst_n) begin
        for (int k = 0; k < 2; k++) begin
            logic [3:0] msk, nst;
            bit shd_ok;
            msk    = (k == 0) ? 4'hF : 4'h9;
            shd_ok = (k == 0);
            if (!rst_n) begin
                m_st[k] = 0; m_es[k] = 0; m_ss[k] = 0;
            end else if (exc_valid && (exc_cause != 0 || m_st[k][0])) begin
                if (exc_cause != 1 && !m_st[k][2]) begin
                    if (exc_cause == 0 && shd_req && shd_set != 0 && shd_ok) m_ss[k] = m_st[k];
                    else m_es[k] = m_st[k];
                end
                nst = m_st[k];
                nst[0] = 0; nst[1] = 0; nst[2] = 1;
                if (exc_cause == 0) nst[3] = 1;
                m_st[k] = nst & msk;
            end else if (eret) begin
                m_st[k] = ((eret_shd && shd_ok) ? m_ss[k] : m_es[k]) & msk;
            end else if (sw_we) begin
                case (sw_addr)
                    2'd0: m_st[k] = sw_wdata[3:0] & msk;
                    2'd1: m_es[k] = sw_wdata[3:0] & msk;
                    2'd2: if (shd_ok) m_ss[k] = sw_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(int k);
        case (sw_addr)
            2'd0: return 32'(m_st[k]);
            2'd1: return 32'(m_es[k]);
            2'd2: return 32'(m_ss[k]);
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk1(string what, int k, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s dut%0d %s act=%h exp=%h", cur_req, k, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] st, es, ss, rd;
        logic        g;
        for (int k = 0; k < 2; k++) begin
            st = k ? st_b : st_a; es = k ? es_b : es_a; ss = k ? ss_b : ss_a;
            rd = k ? rd_b : rd_a; g = k ? g_b : g_a;
            n_chk++;
            chk1("status", k, st, 32'(m_st[k]));
            chk1("estatus", k, es, 32'(m_es[k]));
            chk1("sstatus", k, ss, 32'(m_ss[k]));
            chk1("rdata", k, rd, exp_rd(k));
            chk1("irq_gate R12", k, 32'(g), 32'(m_st[k][0]));
            n_chk++;
            if (st[2] && st[1]) begin
                n_bad++;
                $display("FAIL R11 dut%0d EXM and USR both set act=%h exp=0", k, st[2:1]);
            end
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (rst_n && !done) compare();
    end

    task automatic cyc(logic v, logic [1:0] c, logic sr, logic [2:0] s, logic er,
                       logic ers, logic we, logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        exc_valid = v; exc_cause = c; shd_req = sr; shd_set = s; eret = er;
        eret_shd = ers; sw_we = we; sw_addr = a; sw_wdata = d;
    endtask

    task automatic idle(logic [1:0] a);
        cyc(0, 0, 0, 0, 0, 0, 0, a, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_bad++; n_chk++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        idle(0); idle(1); idle(2);
        cur_req = "R2";
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFF5); idle(0);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_000A); idle(1);
        cyc(0, 0, 0, 0, 0, 0, 1, 2, 32'h1234_5679); idle(2);
        cyc(0, 0, 0, 0, 0, 0, 1, 3, 32'hFFFF_FFFF); idle(3);
        cur_req = "R3 R4 R6";
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'h3); idle(0);
        cyc(1, 2, 0, 0, 0, 0, 0, 1, 0); idle(1);
        cyc(1, 3, 0, 0, 0, 0, 0, 1, 0); idle(1);
        cur_req = "R5 R6 break";
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'h1);
        cyc(1, 1, 0, 0, 0, 0, 0, 1, 0); idle(0);
        cur_req = "R8";
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'h0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0); idle(1);
        cyc(1, 2, 0, 0, 0, 0, 0, 0, 0); idle(0);
        cur_req = "R5 irq";
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'h1);
        cyc(1, 0, 0, 0, 0, 0, 0, 1, 0); idle(0);
        cur_req = "R9";
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); idle(0);
        cur_req = "R7";
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'hB);
        cyc(1, 0, 1, 3'd2, 0, 0, 0, 2, 0); idle(2);
        cyc(0, 0, 0, 0, 1, 1, 0, 0, 0); idle(0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'h1);
        cyc(1, 0, 1, 3'd0, 0, 0, 0, 1, 0); idle(2);
        cur_req = "R10";
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'h1);
        cyc(1, 2, 0, 0, 1, 0, 1, 1, 32'hF); idle(1);
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 32'h8); idle(0);
        cyc(1, 0, 0, 0, 1, 0, 1, 0, 32'h2); idle(0);
        cur_req = "random R2-mix";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d;
            d = $urandom;
            if (d[2]) d[1] = 1'b0;
            cyc(($urandom % 4) == 0, 2'($urandom), $urandom % 2 == 0, 3'($urandom),
                ($urandom % 5) == 0, $urandom % 2 == 0, ($urandom % 3) == 0,
                2'($urandom), d);
        end
        idle(0);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule